// File: doc/BRIEF.md
# Indirect Statistics Counter Window

This block holds a bank of packet statistics counters and exposes them to a host through a small indirect window on a byte-wide register bus. Each port owns a group of event counters, each fed by a one-cycle increment strobe. A separate shared group of narrower dropped-packet counters is fed the same way. The host never addresses a counter directly. It writes a counter number into a selector register and then writes zero to a trigger register. After a fixed delay the chosen value appears in four byte registers, together with a valid flag that the host polls.

Per-port counters are cleared by the act of being read out. An increment strobe that lands in the clearing cycle is kept, so no event is lost. The shared drop counters keep counting across reads. They carry neither a valid flag nor any overflow indication, so the host is expected to sample them often enough to track wrap-around itself. A selector that names no counter returns a zero value marked valid, which keeps a polling host from stalling.

Top module: `stat_window`

## Requirements
- R1: A write of 0x00 to the trigger register (address 1) starts a capture of the counter named by the selector register (address 0). Selector values 0 to NUM_PORTS*PORT_CNTS-1 name per-port counters, where per-port counter n counts strobes on `port_evt[n]`. A write of any other value to the trigger register starts nothing and clears nothing.
- R2: The register map is: 0 selector (read/write), 1 trigger (reads 0x00), 2..5 latched word bytes in descending significance (2 = bits 31:24 through 5 = bits 7:0), and 6..7 read 0x00. `reg_rdata` shows the register addressed in the previous cycle.
- R3: Bit 30 of the latched word (bit 6 of address 2) is the valid flag. It clears at the clock edge that takes a trigger write and sets exactly LAT cycles later. Bit 31 always reads 0.
- R4: The value bits of the latched word change only at the capture edge that follows a trigger. Between captures they hold still while the counters keep counting.
- R5: A per-port counter is CNT_W bits wide (30 by default). It is placed zero-extended in bits 29:0 and wraps silently modulo 2^CNT_W.
- R6: The per-port counter that is captured is cleared at the capture edge. The captured word holds its value from just before that edge.
- R7: If the counter's own increment strobe is high in the capture cycle, the counter restarts at 1 instead of 0.
- R8: Selector values NUM_PORTS*PORT_CNTS to NUM_PORTS*PORT_CNTS+NUM_DROP-1 name the drop counters, in order, fed by `drop_evt`. A drop counter is DROP_W bits wide (16 by default) and is returned in the two low bytes. Bits 31:16 are zero, the valid flag included. It is never cleared by a capture and wraps modulo 2^DROP_W.
- R9: A selector value above the last drop counter captures the word 0x4000_0000: value zero, valid set.
- R10: After reset all counters, the selector and the latched word are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write enable, sampled on the clock edge |
| reg_addr | input | 3 | Register address for both writes and reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's address |
| port_evt | input | NUM_PORTS*PORT_CNTS | Per-port counter increment strobes, one bit per counter |
| drop_evt | input | NUM_DROP | Shared drop counter increment strobes |

## Verification
The bench builds the block with two ports of three counters, two drop counters, CNT_W=10, DROP_W=6 and LAT=4. The narrow widths let both counter kinds wrap within a few thousand cycles of random strobes, which brings the silent-wrap behaviour of R5 and R8 within reach of a short run. The selector space is then small enough that random selectors regularly fall on per-port, drop and unmapped entries alike. LAT=4 leaves room to place a strobe on the exact capture cycle and to poll the valid flag through several cleared cycles.

// File: rtl/stat_pkg.sv
// Package: register addresses and word layout shared by the counter window.
// Assumes a 3-bit register address and an 8-bit data bus.
package stat_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] RA_SEL  = 3'd0;
    localparam logic [REG_AW-1:0] RA_TRIG = 3'd1;
    localparam logic [REG_AW-1:0] RA_B3   = 3'd2;
    localparam logic [REG_AW-1:0] RA_B2   = 3'd3;
    localparam logic [REG_AW-1:0] RA_B1   = 3'd4;
    localparam logic [REG_AW-1:0] RA_B0   = 3'd5;

    localparam int          VALID_POS  = 30;
    localparam logic [31:0] VALID_MASK = 32'h4000_0000;
endpackage

// File: rtl/stat_cnt_cell.sv
// Module: one statistics counter with an optional clear.
// It counts one per cycle while inc is high and wraps silently.
// A clear takes priority, but an increment in that same cycle is kept,
// so the counter restarts at one. Assumes clr is a single-cycle pulse.
module stat_cnt_cell #(
    parameter int WIDTH = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [WIDTH-1:0] val
);
    // Purpose: update the count on clear and increment strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val <= '0;
        end else if (clr) begin
            val <= WIDTH'(inc);
        end else if (inc) begin
            val <= val + 1'b1;
        end
    end
endmodule

// File: rtl/stat_read_seq.sv
// Module: sequencer for the indirect read.
// A trigger latches the selector and starts a countdown. When the countdown
// expires it raises cap for one cycle. A new trigger restarts the countdown
// and suppresses any capture that falls in the same cycle.
// Assumes LAT >= 1.
module stat_read_seq #(
    parameter int SEL_W = 8,
    parameter int LAT   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [SEL_W-1:0] sel_in,
    output logic [SEL_W-1:0] sel_held,
    output logic             cap
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] wait_cnt;

    // Purpose: load the countdown and hold the selector on a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
            sel_held <= '0;
        end else if (trig) begin
            wait_cnt <= CW'(LAT);
            sel_held <= sel_in;
        end else if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - 1'b1;
        end
    end

    // Purpose: fire the capture strobe in the last countdown cycle.
    always_comb cap = (wait_cnt == CW'(1)) && !trig;
endmodule

// File: rtl/stat_window.sv
// Module: statistics counter bank behind an indirect byte-wide window.
// The host writes a selector, then writes zero to the trigger register.
// LAT cycles later the selected counter is latched into a 32-bit word,
// which is read back as four bytes. Per-port counters clear on capture.
// Drop counters persist. Assumes SEL_W <= 8 and CNT_W <= 30.
// Also assumes DROP_W <= 16 and that the selector space covers all counters.
module stat_window
    import stat_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_CNTS = 9,
    parameter int NUM_DROP  = 4,
    parameter int CNT_W     = 30,
    parameter int DROP_W    = 16,
    parameter int SEL_W     = 8,
    parameter int LAT       = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_wr,
    input  logic [REG_AW-1:0]              reg_addr,
    input  logic [7:0]                     reg_wdata,
    output logic [7:0]                     reg_rdata,
    input  logic [NUM_PORTS*PORT_CNTS-1:0] port_evt,
    input  logic [NUM_DROP-1:0]            drop_evt
);
    localparam int NPC = NUM_PORTS * PORT_CNTS;

    logic                             trig_fire;
    logic                             cap_pulse;
    logic [SEL_W-1:0]                 sel_reg;
    logic [SEL_W-1:0]                 sel_held;
    logic [NPC-1:0][CNT_W-1:0]        port_val;
    logic [NPC-1:0]                   port_clr;
    logic [NUM_DROP-1:0][DROP_W-1:0]  drop_val;
    logic [31:0]                      cap_word;
    logic [31:0]                      word_q;

    // Purpose: decode a zero write to the trigger register.
    always_comb trig_fire = reg_wr && (reg_addr == RA_TRIG) && (reg_wdata == 8'h00);

    // Purpose: hold the host-written counter selector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_reg <= '0;
        end else if (reg_wr && (reg_addr == RA_SEL)) begin
            sel_reg <= reg_wdata[SEL_W-1:0];
        end
    end

    stat_read_seq #(
        .SEL_W (SEL_W),
        .LAT   (LAT)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig_fire),
        .sel_in   (sel_reg),
        .sel_held (sel_held),
        .cap      (cap_pulse)
    );

    for (genvar g = 0; g < NPC; g++) begin : g_port
        // Purpose: clear this counter when it is the one captured.
        always_comb port_clr[g] = cap_pulse && (sel_held == SEL_W'(g));

        stat_cnt_cell #(.WIDTH(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (port_evt[g]),
            .clr   (port_clr[g]),
            .val   (port_val[g])
        );
    end

    for (genvar d = 0; d < NUM_DROP; d++) begin : g_drop
        stat_cnt_cell #(.WIDTH(DROP_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (drop_evt[d]),
            .clr   (1'b0),
            .val   (drop_val[d])
        );
    end

    // Purpose: select the word to capture from the held selector.
    always_comb begin
        cap_word = VALID_MASK;
        for (int i = 0; i < NPC; i++) begin
            if (sel_held == SEL_W'(i)) cap_word = VALID_MASK | 32'(port_val[i]);
        end
        for (int j = 0; j < NUM_DROP; j++) begin
            if (sel_held == SEL_W'(NPC + j)) cap_word = 32'(drop_val[j]);
        end
    end

    // Purpose: latch the captured word and drop the valid flag on a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (cap_pulse) begin
            word_q <= cap_word;
        end else if (trig_fire) begin
            word_q[VALID_POS] <= 1'b0;
        end
    end

    // Purpose: registered read mux, one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else begin
            case (reg_addr)
                RA_SEL:  reg_rdata <= 8'(sel_reg);
                RA_B3:   reg_rdata <= word_q[31:24];
                RA_B2:   reg_rdata <= word_q[23:16];
                RA_B1:   reg_rdata <= word_q[15:8];
                RA_B0:   reg_rdata <= word_q[7:0];
                default: reg_rdata <= 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/stat_window_chk.sv
// Module: assertion checker bound into stat_window.
// It watches the bus, the latched word and the first counter of each kind.
module stat_window_chk
    import stat_pkg::*;
#(
    parameter int CNT_W  = 30,
    parameter int DROP_W = 16,
    parameter int SEL_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] reg_addr,
    input logic [7:0]        reg_rdata,
    input logic              trig_fire,
    input logic              cap_pulse,
    input logic [SEL_W-1:0]  sel_reg,
    input logic [31:0]       word_q,
    input logic [CNT_W-1:0]  pc0,
    input logic [DROP_W-1:0] dc0
);
    p_trig_drops_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_fire |=> !word_q[VALID_POS]);

    p_top_bit_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == RA_B3) |=> !reg_rdata[7]);

    p_word_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse |=> $stable(word_q[29:0]));

    p_sel_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == RA_SEL) |=> (reg_rdata == 8'($past(sel_reg))));

    p_trig_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == RA_TRIG) |=> (reg_rdata == 8'h00));

    p_port_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc0) |-> ((pc0 == CNT_W'($past(pc0) + 1'b1)) || (pc0 <= CNT_W'(1))));

    p_drop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dc0) |-> (dc0 == DROP_W'($past(dc0) + 1'b1)));
endmodule

bind stat_window stat_window_chk #(
    .CNT_W  (CNT_W),
    .DROP_W (DROP_W),
    .SEL_W  (SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .trig_fire (trig_fire),
    .cap_pulse (cap_pulse),
    .sel_reg   (sel_reg),
    .word_q    (word_q),
    .pc0       (port_val[0]),
    .dc0       (drop_val[0])
);

// File: tb/stat_window_test.sv
// Bench: directed corner cases plus seeded random strobes and selectors,
// checked against a cycle-level counter model kept in the bench.
module stat_window_test;
    localparam int NP  = 2;
    localparam int PC  = 3;
    localparam int ND  = 2;
    localparam int CW  = 10;
    localparam int DW  = 6;
    localparam int LAT = 4;
    localparam int SW  = 8;
    localparam int NPC = NP * PC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [NPC-1:0] port_evt = '0;
    logic [ND-1:0]  drop_evt = '0;

    always #5 clk = ~clk;

    stat_window #(
        .NUM_PORTS (NP),
        .PORT_CNTS (PC),
        .NUM_DROP  (ND),
        .CNT_W     (CW),
        .DROP_W    (DW),
        .SEL_W     (SW),
        .LAT       (LAT)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .port_evt  (port_evt),
        .drop_evt  (drop_evt)
    );

    int          tests = 0;
    int          fails = 0;
    int          cyc = 0;
    int          cap_edge = -1;
    int          cap_sel = 0;
    int          sel_m = 0;
    bit          evt_on = 1'b0;
    logic [31:0] exp_word = '0;
    int unsigned m_port [NPC];
    int unsigned m_drop [ND];

    // Model: counts strobes, clears on capture, records the expected word.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < NPC; i++) m_port[i] = 0;
            for (int i = 0; i < ND; i++) m_drop[i] = 0;
        end else begin
            if (cyc == cap_edge) begin
                if (cap_sel < NPC) exp_word = 32'h4000_0000 | m_port[cap_sel];
                else if (cap_sel < NPC + ND) exp_word = m_drop[cap_sel - NPC];
                else exp_word = 32'h4000_0000;
            end
            for (int i = 0; i < NPC; i++) begin
                if (cyc == cap_edge && cap_sel == i) m_port[i] = port_evt[i] ? 1 : 0;
                else if (port_evt[i]) m_port[i] = (m_port[i] + 1) % (1 << CW);
            end
            for (int i = 0; i < ND; i++) begin
                if (drop_evt[i]) m_drop[i] = (m_drop[i] + 1) % (1 << DW);
            end
        end
    end

    // Random strobe driver, active only while evt_on is set.
    always @(posedge clk) begin
        if (evt_on) begin
            #1;
            port_evt = NPC'($urandom);
            drop_evt = ND'($urandom);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic [2:0] a, logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        if (a == 3'd0) sel_m = int'(d);
        if (a == 3'd1 && d == 8'h00) begin
            cap_edge = cyc + 1 + LAT;
            cap_sel  = sel_m;
        end
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        tick();
        d = reg_rdata;
    endtask

    task automatic rd_word(output logic [31:0] w);
        logic [7:0] b3, b2, b1, b0;
        rd_reg(3'd2, b3);
        rd_reg(3'd3, b2);
        rd_reg(3'd4, b1);
        rd_reg(3'd5, b0);
        w = {b3, b2, b1, b0};
    endtask

    task automatic fetch(int s, output logic [31:0] w);
        wr_reg(3'd0, 8'(s));
        wr_reg(3'd1, 8'h00);
        repeat (LAT) tick();
        rd_word(w);
    endtask

    task automatic evt_stop();
        evt_on = 1'b0;
        tick();
        port_evt = '0;
        drop_evt = '0;
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic [31:0] prev;
        logic [7:0]  b;
        int          s;
        s = int'($urandom(32'd20240607));

        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R10: reset state of selector, latched word and counters
        rd_reg(3'd0, b);
        chk("R10 selector after reset", 32'(b), 32'h0);
        rd_word(w);
        chk("R10 latched word after reset", w, 32'h0);
        fetch(0, w);
        chk("R10 counter zero after reset", w, 32'h4000_0000);

        // R2: selector readback, trigger and unused addresses read zero
        wr_reg(3'd0, 8'h07);
        rd_reg(3'd0, b);
        chk("R2 selector readback", 32'(b), 32'h07);
        rd_reg(3'd1, b);
        chk("R2 trigger reads zero", 32'(b), 32'h0);
        rd_reg(3'd6, b);
        chk("R2 unused address reads zero", 32'(b), 32'h0);

        // R3: valid flag stays low LAT polls, then sets
        port_evt = NPC'(2);
        repeat (5) tick();
        port_evt = '0;
        wr_reg(3'd0, 8'd1);
        wr_reg(3'd1, 8'h00);
        reg_addr = 3'd2;
        for (int j = 0; j < LAT; j++) begin
            tick();
            chk("R3 valid low while waiting", 32'(reg_rdata[7:6]), 32'h0);
        end
        tick();
        chk("R3 valid high after latency", 32'(reg_rdata), 32'h40);
        rd_word(w);
        chk("R5 captured value of counter 1", w, 32'h4000_0005);
        chk("R5 model agrees on counter 1", w, exp_word);

        // R6: second read of the same counter finds it cleared
        fetch(1, w);
        chk("R6 cleared after read", w, 32'h4000_0000);

        // R7: strobe in the capture cycle restarts the counter at one
        port_evt = NPC'(1 << 4);
        repeat (3) tick();
        port_evt = '0;
        wr_reg(3'd0, 8'd4);
        wr_reg(3'd1, 8'h00);
        repeat (LAT - 1) tick();
        port_evt = NPC'(1 << 4);
        tick();
        port_evt = '0;
        rd_word(w);
        chk("R7 value before the coincident clear", w, 32'h4000_0003);
        fetch(4, w);
        chk("R7 counter restarted at one", w, 32'h4000_0001);

        // R9: selectors past the last counter
        fetch(200, w);
        chk("R9 unmapped selector 200", w, 32'h4000_0000);
        fetch(NPC + ND, w);
        chk("R9 first unmapped selector", w, 32'h4000_0000);

        // R8: drop counter layout, no valid flag, persistence
        drop_evt = 2'b10;
        repeat (3) tick();
        drop_evt = '0;
        fetch(NPC + 1, w);
        chk("R8 drop counter value", w, 32'h0000_0003);
        fetch(NPC + 1, w);
        chk("R8 drop counter not cleared", w, 32'h0000_0003);

        // R1 and R4: nonzero trigger starts nothing, word and counter kept
        port_evt = NPC'(1);
        repeat (2) tick();
        port_evt = '0;
        wr_reg(3'd0, 8'd0);
        wr_reg(3'd1, 8'h5A);
        repeat (LAT + 3) tick();
        rd_word(prev);
        chk("R1 nonzero trigger ignored, word held", prev, 32'h0000_0003);
        fetch(0, w);
        chk("R1 counter 0 not cleared by ignored trigger", w, 32'h4000_0002);

        // R4: latched word holds while counters run
        evt_on = 1'b1;
        fetch(2, prev);
        chk("R4 random capture of counter 2", prev, exp_word);
        repeat (50) tick();
        rd_word(w);
        chk("R4 word stable between captures", w, prev);

        // R1 R5 R8 R9: random selectors under random strobes
        for (int k = 0; k < 40; k++) begin
            fetch(int'($urandom_range(0, NPC + ND + 1)), w);
            chk("R1 random selector capture", w, exp_word);
        end

        // R5 R8: long accumulation so every counter wraps
        repeat (3000) tick();
        for (int k = 0; k < NPC; k++) begin
            fetch(k, w);
            chk("R5 per-port counter after wrap", w, exp_word);
        end
        for (int k = 0; k < ND; k++) begin
            fetch(NPC + k, w);
            chk("R8 drop counter after wrap", w, exp_word);
        end
        evt_stop();

        // R6: every per-port counter reads zero after a second read
        for (int k = 0; k < NPC; k++) begin
            fetch(k, w);
            fetch(k, w);
            chk("R6 cleared after read, quiet inputs", w, 32'h4000_0000);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule